// File: doc/BRIEF.md
# External Interrupt and Keyscan Request Gatherer

This block collects external interrupt requests for a CPU core. One source is a dedicated active-low interrupt pin. The others are a bank of keyscan port inputs. A key input counts as a source only while its pullup enable is set. The sources are active low and are merged into one combined line, which is low whenever any enabled source is low. All asynchronous pins are brought into the clock domain through a synchronizer chain before they are merged.

A falling edge on the combined line sets a pending-request latch. Only reset or the CPU's interrupt vector fetch clears it. When a new falling edge meets a vector fetch in the same cycle, the new request wins and the latch stays set. A strap input selects the detection mode. In edge mode, only the latch raises a request. In level mode, a low combined line also raises a request directly, for as long as it stays low.

The request to the CPU is held off while the CPU's global mask bit is set or the external-interrupt enable is clear. The latch keeps capturing during that time, so a request that arrived while held off is delivered once both gates open. A separate output gives the unlatched level of the combined line, for use by branch-on-pin-level instructions.

The block has no data streams, so it has no valid/ready interface. Every port is a plain control or status pin, and none of them applies back-pressure.

Top module: `extint_gather`

## Requirements
- R1: While reset is asserted and right after it is released, `cpu_irq` is 0 and `pin_sense` is 1. The synchronizers come up at the idle-high level and the latch comes up clear.
- R2: `pin_sense` follows the combined line two clock edges after a pin change. The combined line is high (1) only when `irq_pin_n` is high and every key with `key_pull_en` = 1 is high.
- R3: A key whose `key_pull_en` bit is 0 has no effect on `pin_sense`, on the latch, or on `cpu_irq`, whatever its level.
- R4: In edge mode (`level_mode` = 0), a falling edge of the combined line sets the pending latch. `cpu_irq` rises at the third clock edge after the pin falls, provided the gates are open.
- R5: Once set, the pending latch stays set after the combined line returns high, for any number of cycles, until a vector fetch or reset.
- R6: A one-cycle `vec_fetch` pulse clears the pending latch at the next clock edge. In edge mode, with the line high, `cpu_irq` then falls.
- R7: If a falling edge and `vec_fetch` fall on the same cycle, the latch is left set after that edge.
- R8: While `cpu_imask` = 1, `cpu_irq` is 0. The latch still captures edges, and `cpu_irq` rises in the same cycle that `cpu_imask` returns to 0.
- R9: While `ext_int_en` = 0, `cpu_irq` is 0. The latch still captures edges, and `cpu_irq` rises in the same cycle that `ext_int_en` returns to 1.
- R10: In level mode (`level_mode` = 1), `cpu_irq` is 1 whenever the synchronized combined line is low and the gates are open, even after a vector fetch has cleared the latch. It drops two edges after the line returns high, provided the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Raw dedicated interrupt pin, active low, asynchronous |
| key_pins | input | NUM_KEYS | Raw keyscan port pin levels, active low, asynchronous |
| key_pull_en | input | NUM_KEYS | Per-key pullup enable; 1 makes that key an interrupt source |
| cpu_imask | input | 1 | CPU global interrupt mask; 1 holds off the request |
| ext_int_en | input | 1 | External interrupt enable; 0 holds off the request |
| level_mode | input | 1 | Detection strap: 0 edge only, 1 level and edge |
| vec_fetch | input | 1 | One-cycle strobe when the CPU fetches the interrupt vector |
| cpu_irq | output | 1 | Interrupt request to the CPU core |
| pin_sense | output | 1 | Unlatched level of the combined line for pin-level branches |

## Verification
The bench builds the block with eight keys and a two-stage synchronizer. The reference model reads its delay from the same stage count, so the exact edge on which `pin_sense` and `cpu_irq` move is checked against the counted latency. With eight keys, the bench can keep one key with its pullup disabled held low for many cycles and then enable that pullup. This tests the case where the combined line falls because an enable changed rather than a pin. The coincident edge-and-fetch case and both hold-off gates are each driven with a request already pending.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } det_mode_e;

  typedef enum logic [1:0] {
    PEND_HOLD  = 2'd0,
    PEND_SET   = 2'd1,
    PEND_CLEAR = 2'd2
  } pend_act_e;

  function automatic pend_act_e pend_decide(input logic fall, input logic clr);
    if (fall)     return PEND_SET;
    else if (clr) return PEND_CLEAR;
    else          return PEND_HOLD;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("extint_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
  end

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/extint_merge.sv
module extint_merge #(
  parameter int NUM_KEYS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_s,
  input  logic [NUM_KEYS-1:0] key_s,
  input  logic [NUM_KEYS-1:0] pull_en,
  output logic                comb_n
);
  logic [NUM_KEYS-1:0] key_hit;

  generate
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      assign key_hit[k] = pull_en[k] & ~key_s[k];
    end
  endgenerate

  assign comb_n = irq_s & ~(|key_hit);

  // R2: a low dedicated pin always drives the combined line low
  p_pin_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_s |-> !comb_n);

  // R3: with every key input high, the pullup enables cannot pull the line low
  p_idle_keys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_s && (&key_s)) |-> comb_n);

endmodule

// File: rtl/extint_latch.sv
module extint_latch
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic comb_n,
  input  logic vec_fetch,
  input  logic level_mode,
  input  logic cpu_imask,
  input  logic ext_int_en,
  output logic pending,
  output logic cpu_irq
);
  logic      prev_q;
  logic      fall;
  pend_act_e act;
  det_mode_e mode;
  logic      level_req;

  assign fall = prev_q & ~comb_n;
  assign act  = pend_decide(fall, vec_fetch);
  assign mode = det_mode_e'(level_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= comb_n;
      case (act)
        PEND_SET:   pending <= 1'b1;
        PEND_CLEAR: pending <= 1'b0;
        default:    pending <= pending;
      endcase
    end
  end

  always_comb begin
    level_req = 1'b0;
    if (mode == DET_LEVEL) level_req = ~comb_n;
  end

  assign cpu_irq = (pending | level_req) & ~cpu_imask & ext_int_en;

  // R4: a fall on the combined line sets the latch
  p_fall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && !comb_n) |=> pending);

  // R5: with no fall and no fetch the latch keeps its value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(prev_q && !comb_n) && !vec_fetch) |=> $stable(pending));

  // R6: a fetch with no new fall clears the latch
  p_fetch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && !(prev_q && !comb_n)) |=> !pending);

  // R7: a fall coinciding with a fetch leaves the latch set
  p_fall_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && prev_q && !comb_n) |=> pending);

endmodule

// File: rtl/extint_gather.sv
module extint_gather
  import extint_pkg::*;
#(
  parameter int NUM_KEYS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_pin_n,
  input  logic [NUM_KEYS-1:0] key_pins,
  input  logic [NUM_KEYS-1:0] key_pull_en,
  input  logic                cpu_imask,
  input  logic                ext_int_en,
  input  logic                level_mode,
  input  logic                vec_fetch,
  output logic                cpu_irq,
  output logic                pin_sense
);
  localparam int RAW_W = NUM_KEYS + 1;

  logic [RAW_W-1:0]    raw_bus;
  logic [RAW_W-1:0]    sync_bus;
  logic                irq_s;
  logic [NUM_KEYS-1:0] key_s;
  logic                comb_n;
  logic                pending;

  assign raw_bus = {irq_pin_n, key_pins};

  extint_sync #(
    .WIDTH   (RAW_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_bus),
    .dout  (sync_bus)
  );

  assign irq_s = sync_bus[RAW_W-1];
  assign key_s = sync_bus[NUM_KEYS-1:0];

  extint_merge #(
    .NUM_KEYS (NUM_KEYS)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_s   (irq_s),
    .key_s   (key_s),
    .pull_en (key_pull_en),
    .comb_n  (comb_n)
  );

  extint_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .comb_n     (comb_n),
    .vec_fetch  (vec_fetch),
    .level_mode (level_mode),
    .cpu_imask  (cpu_imask),
    .ext_int_en (ext_int_en),
    .pending    (pending),
    .cpu_irq    (cpu_irq)
  );

  assign pin_sense = comb_n;

  // R8: the global mask holds the request off
  p_mask_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_imask |-> !cpu_irq);

  // R9: a disabled external path holds the request off
  p_enable_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_int_en |-> !cpu_irq);

  // R8: a pending request reaches the CPU whenever both gates are open
  p_pending_delivered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !cpu_imask && ext_int_en) |-> cpu_irq);

endmodule

// File: tb/sim_extint_gather.sv
module sim_extint_gather;
  localparam int NK   = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_pin_n = 1'b1;
  logic [NK-1:0] key_pins = '1;
  logic [NK-1:0] key_pull_en = '1;
  logic          cpu_imask = 1'b0;
  logic          ext_int_en = 1'b1;
  logic          level_mode = 1'b0;
  logic          vec_fetch = 1'b0;
  logic          cpu_irq;
  logic          pin_sense;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  extint_gather #(.NUM_KEYS(NK), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .key_pins(key_pins),
    .key_pull_en(key_pull_en), .cpu_imask(cpu_imask), .ext_int_en(ext_int_en),
    .level_mode(level_mode), .vec_fetch(vec_fetch),
    .cpu_irq(cpu_irq), .pin_sense(pin_sense)
  );

  // Reference model: queues hold the pin history, newest at the front
  bit            pq[$];
  logic [NK-1:0] kq[$];
  bit            m_prev;
  bit            m_pend;

  task automatic model_init();
    pq.delete();
    kq.delete();
    for (int i = 0; i < SYNC; i++) begin
      pq.push_back(1'b1);
      kq.push_back('1);
    end
    m_prev = 1'b1;
    m_pend = 1'b0;
  endtask

  function automatic bit line_now();
    return pq[SYNC-1] & ~(|(~kq[SYNC-1] & key_pull_en));
  endfunction

  initial model_init();

  always @(posedge clk) begin
    if (!rst_n) model_init();
    else begin
      bit c;
      c = line_now();
      if (m_prev && !c) m_pend = 1'b1;
      else if (vec_fetch) m_pend = 1'b0;
      m_prev = c;
      pq.push_front(irq_pin_n);
      void'(pq.pop_back());
      kq.push_front(key_pins);
      void'(kq.pop_back());
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit c;
      bit e_irq;
      c = line_now();
      e_irq = (m_pend | (level_mode & ~c)) & ~cpu_imask & ext_int_en;
      chk({cur_req, " model pin_sense"}, pin_sense, c);
      chk({cur_req, " model cpu_irq"}, cpu_irq, e_irq);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fetch();
    vec_fetch = 1'b1;
    edges(1);
    vec_fetch = 1'b0;
  endtask

  initial begin
    // R1: reset state
    edges(3);
    @(negedge clk);
    chk("R1 irq in reset", cpu_irq, 1'b0);
    chk("R1 sense in reset", pin_sense, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", cpu_irq, 1'b0);
    chk("R1 sense after reset", pin_sense, 1'b1);
    edges(2);

    // R2 and R4: dedicated pin falls in edge mode
    cur_req = "R4";
    irq_pin_n = 1'b0;
    edges(1);
    @(negedge clk);
    chk("R2 sense before two edges", pin_sense, 1'b1);
    @(negedge clk);
    chk("R2 sense after two edges", pin_sense, 1'b0);
    chk("R4 no request before latch", cpu_irq, 1'b0);
    @(negedge clk);
    chk("R4 request on third edge", cpu_irq, 1'b1);

    // R5: latch holds after release
    cur_req = "R5";
    @(posedge clk); #1;
    irq_pin_n = 1'b1;
    edges(6);
    @(negedge clk);
    chk("R5 request held", cpu_irq, 1'b1);
    chk("R5 sense back high", pin_sense, 1'b1);

    // R6: vector fetch clears
    cur_req = "R6";
    @(posedge clk); #1;
    fetch();
    @(negedge clk);
    chk("R6 request cleared", cpu_irq, 1'b0);

    // R3: disabled key ignored, then enabled
    cur_req = "R3";
    @(posedge clk); #1;
    key_pull_en = 8'hF7;
    key_pins[3] = 1'b0;
    edges(6);
    @(negedge clk);
    chk("R3 disabled key no request", cpu_irq, 1'b0);
    chk("R3 disabled key no sense", pin_sense, 1'b1);
    @(posedge clk); #1;
    key_pull_en = 8'hFF;
    @(negedge clk);
    chk("R2 sense follows enabled key", pin_sense, 1'b0);
    @(negedge clk);
    chk("R4 enabled key sets latch", cpu_irq, 1'b1);
    @(posedge clk); #1;
    key_pins[3] = 1'b1;
    edges(3);
    fetch();
    edges(2);

    // R8: global mask holds off but latch captures
    cur_req = "R8";
    cpu_imask = 1'b1;
    irq_pin_n = 1'b0;
    edges(4);
    irq_pin_n = 1'b1;
    edges(3);
    @(negedge clk);
    chk("R8 masked request off", cpu_irq, 1'b0);
    @(posedge clk); #1;
    cpu_imask = 1'b0;
    @(negedge clk);
    chk("R8 delivered on unmask", cpu_irq, 1'b1);
    @(posedge clk); #1;
    fetch();
    edges(2);

    // R9: external enable holds off but latch captures
    cur_req = "R9";
    ext_int_en = 1'b0;
    key_pins[7] = 1'b0;
    edges(4);
    key_pins[7] = 1'b1;
    edges(3);
    @(negedge clk);
    chk("R9 disabled request off", cpu_irq, 1'b0);
    @(posedge clk); #1;
    ext_int_en = 1'b1;
    @(negedge clk);
    chk("R9 delivered on enable", cpu_irq, 1'b1);
    @(posedge clk); #1;
    fetch();
    edges(2);

    // R7: fall coinciding with fetch, latch already set
    cur_req = "R7";
    irq_pin_n = 1'b0;
    edges(4);
    irq_pin_n = 1'b1;
    edges(4);
    irq_pin_n = 1'b0;
    edges(2);
    vec_fetch = 1'b1;
    edges(1);
    vec_fetch = 1'b0;
    @(negedge clk);
    chk("R7 new fall survives fetch", cpu_irq, 1'b1);
    @(posedge clk); #1;
    irq_pin_n = 1'b1;
    edges(3);
    fetch();
    edges(2);

    // R10: level mode
    cur_req = "R10";
    level_mode = 1'b1;
    irq_pin_n = 1'b0;
    edges(1);
    @(negedge clk);
    chk("R10 no request before sync", cpu_irq, 1'b0);
    @(negedge clk);
    chk("R10 level request", cpu_irq, 1'b1);
    @(posedge clk); #1;
    edges(2);
    fetch();
    @(negedge clk);
    chk("R10 level request survives fetch", cpu_irq, 1'b1);
    @(posedge clk); #1;
    irq_pin_n = 1'b1;
    edges(1);
    @(negedge clk);
    chk("R10 still low after one edge", cpu_irq, 1'b1);
    @(negedge clk);
    chk("R10 drops after release", cpu_irq, 1'b0);
    @(posedge clk); #1;
    level_mode = 1'b0;
    edges(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule